// File: doc/BRIEF.md
# Tag-Wakeup Instruction Issue Window

This block holds instructions that have been dispatched but not yet sent to the execution units. Each slot records the instruction's own tag, its operation class, and two source operands. Each operand is a producer tag with a ready flag. A slot may issue once both of its operands are ready. Operands become ready in one of three ways: they arrive ready, they carry the reserved "no producer" tag, or a completion broadcast names their producer.

Up to two instructions arrive per cycle. Two completion buses are compared against every stored operand and against every arriving operand. A broadcast that completes the last missing operand of a stored slot lets that slot issue in the same cycle. Up to `ISSUE_W` ready slots leave per cycle, and the oldest go first. Surviving slots then shift down toward slot 0, and new arrivals are appended behind them, so slot order is always age order. Arrivals are taken all-or-nothing: the offered group is accepted only if it fits in the slots that are free at the start of the cycle.

Top module: `iw_issue_window`

## Requirements
- R1: After reset the window is empty. `iss_vld` is all zero, and `ins_ready` is high even when both insert lanes are offered.
- R2: Each cycle, every insert lane with `ins_vld` set is written into the window, provided `ins_ready` is high. Lane 0 counts as older than lane 1. An inserted instruction issues no earlier than the following cycle.
- R3: A source whose producer tag is all ones (63 with the default 6-bit tag) has no producer. It counts as ready whatever its ready flag says.
- R4: A source inserted with its ready flag set counts as ready.
- R5: When `cmp_vld[p]` is high, every stored source whose tag equals `cmp_tag[p]` becomes ready and stays ready. A slot whose last missing source is completed this way issues in that same cycle.
- R6: Both broadcast ports are compared against every source. A slot whose two sources are woken one by each port, in the same cycle or in different cycles, becomes issuable.
- R7: A broadcast in the same cycle as an insertion wakes the matching source of the arriving instruction. That instruction issues on the next cycle without any further broadcast.
- R8: Among issuable slots, the lowest-numbered (oldest) are chosen, at most `ISSUE_W` (2) per cycle. Issue port 0 carries the older instruction, and port 1 is valid only when port 0 is.
- R9: Issued slots are removed, and the remaining slots close up toward slot 0 in their original relative order. Wakeups recorded before the shift are kept.
- R10: `ins_ready` is high exactly when the number of set `ins_vld` bits is no more than `DEPTH` minus the occupancy at the start of the cycle. When `ins_ready` is low, no offered instruction enters.
- R11: An issued instruction never issues a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| ins_vld | input | 2 | Insert lane valid, one bit per lane |
| ins_tag | input | 2×TAG_W | Tag of the instruction on each lane |
| ins_op | input | 2×OP_W | Operation class on each lane |
| ins_src_tag | input | 2×2×TAG_W | Producer tag per lane and source; all ones means no producer |
| ins_src_rdy | input | 2×2 | Ready flag per lane and source |
| ins_ready | output | 1 | The offered lanes fit and are accepted this cycle |
| cmp_vld | input | 2 | Completion broadcast valid, one bit per port |
| cmp_tag | input | 2×TAG_W | Tag being completed on each port |
| iss_vld | output | ISSUE_W | Issue port valid; port 0 is the oldest |
| iss_tag | output | ISSUE_W×TAG_W | Tag of the instruction on each issue port |
| iss_op | output | ISSUE_W×OP_W | Operation class on each issue port |

## Verification
The two functions most likely to collide are wakeup and issue. Within a single cycle, a broadcast can complete a slot's last operand, and that slot must then be selected. The bench provokes this by holding slots on one missing producer and broadcasting that tag. It expects the dependent slot on the issue port in that same cycle, and expects the port to be empty on the cycle before.

Wakeup and insertion also collide when a broadcast coincides with arrival of its consumer. Issue and compaction collide when younger slots woken in one cycle must come out in age order on the cycles that follow, after the older slots have left.

// File: rtl/iw_pkg.sv
package iw_pkg;
  // Fixed structural counts of the window.
  localparam int unsigned NSRC = 2;  // source operands per instruction
  localparam int unsigned NINS = 2;  // insert lanes per cycle
  localparam int unsigned NCMP = 2;  // completion broadcast ports
endpackage

// File: rtl/iw_wake.sv
// Ready evaluation for N source fields against all completion ports.
module iw_wake
  import iw_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned N     = 2
) (
  input  logic [N-1:0][TAG_W-1:0]    src_tag,
  input  logic [N-1:0]               src_rdy,
  input  logic [NCMP-1:0]            cmp_vld,
  input  logic [NCMP-1:0][TAG_W-1:0] cmp_tag,
  output logic [N-1:0]               src_ok
);
  localparam logic [TAG_W-1:0] NO_PROD = '1;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic [NCMP-1:0] hit;
    for (genvar c = 0; c < NCMP; c++) begin : g_port
      assign hit[c] = cmp_vld[c] && (cmp_tag[c] == src_tag[g]);
    end
    assign src_ok[g] = src_rdy[g] | (src_tag[g] == NO_PROD) | (|hit);
  end
endmodule

// File: rtl/iw_pick.sv
// Oldest-first selection of up to ISSUE_W requesting slots.
module iw_pick #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ISSUE_W = 2,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]              req,
  output logic [DEPTH-1:0]              gnt,
  output logic [ISSUE_W-1:0]            pick_vld,
  output logic [ISSUE_W-1:0][IDX_W-1:0] pick_idx
);
  logic [DEPTH-1:0][CW-1:0] below;  // requests in lower slots
  logic [CW-1:0]            run;

  always_comb begin
    run = '0;
    for (int i = 0; i < DEPTH; i++) begin
      below[i] = run;
      run      = run + CW'(req[i]);
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      gnt[i] = req[i] && (below[i] < CW'(ISSUE_W));
    end
  end

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      pick_vld[k] = 1'b0;
      pick_idx[k] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (req[i] && (below[i] == CW'(k))) begin
          pick_vld[k] = 1'b1;
          pick_idx[k] = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/iw_pack.sv
// Next-state builder: survivors close up toward slot 0, arrivals appended.
module iw_pack
  import iw_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned OP_W  = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]                      cur_vld,
  input  logic [DEPTH-1:0][TAG_W-1:0]           cur_tag,
  input  logic [DEPTH-1:0][OP_W-1:0]            cur_op,
  input  logic [DEPTH-1:0][NSRC-1:0][TAG_W-1:0] cur_stag,
  input  logic [DEPTH-1:0][NSRC-1:0]            cur_srdy,
  input  logic [DEPTH-1:0]                      gnt,
  input  logic [NINS-1:0]                       ins_take,
  input  logic [NINS-1:0][TAG_W-1:0]            ins_tag,
  input  logic [NINS-1:0][OP_W-1:0]             ins_op,
  input  logic [NINS-1:0][NSRC-1:0][TAG_W-1:0]  ins_stag,
  input  logic [NINS-1:0][NSRC-1:0]             ins_srdy,
  output logic [DEPTH-1:0]                      nxt_vld,
  output logic [DEPTH-1:0][TAG_W-1:0]           nxt_tag,
  output logic [DEPTH-1:0][OP_W-1:0]            nxt_op,
  output logic [DEPTH-1:0][NSRC-1:0][TAG_W-1:0] nxt_stag,
  output logic [DEPTH-1:0][NSRC-1:0]            nxt_srdy
);
  logic [DEPTH-1:0]         keep;
  logic [DEPTH-1:0][CW-1:0] dst;
  logic [NINS-1:0][CW-1:0]  lane_dst;
  logic [CW-1:0]            run;
  logic [CW-1:0]            lrun;

  assign keep = cur_vld & ~gnt;

  // Destination of each survivor and each accepted lane.
  always_comb begin
    run = '0;
    for (int i = 0; i < DEPTH; i++) begin
      dst[i] = run;
      run    = run + CW'(keep[i]);
    end
    lrun = run;
    for (int l = 0; l < NINS; l++) begin
      lane_dst[l] = lrun;
      lrun        = lrun + CW'(ins_take[l]);
    end
  end

  always_comb begin
    for (int d = 0; d < DEPTH; d++) begin
      nxt_vld[d]  = 1'b0;
      nxt_tag[d]  = '0;
      nxt_op[d]   = '0;
      nxt_stag[d] = '0;
      nxt_srdy[d] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (keep[i] && (dst[i] == CW'(d))) begin
          nxt_vld[d]  = 1'b1;
          nxt_tag[d]  = cur_tag[i];
          nxt_op[d]   = cur_op[i];
          nxt_stag[d] = cur_stag[i];
          nxt_srdy[d] = cur_srdy[i];
        end
      end
      for (int l = 0; l < NINS; l++) begin
        if (ins_take[l] && (lane_dst[l] == CW'(d))) begin
          nxt_vld[d]  = 1'b1;
          nxt_tag[d]  = ins_tag[l];
          nxt_op[d]   = ins_op[l];
          nxt_stag[d] = ins_stag[l];
          nxt_srdy[d] = ins_srdy[l];
        end
      end
    end
  end
endmodule

// File: rtl/iw_issue_window.sv
module iw_issue_window
  import iw_pkg::*;
#(
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned OP_W    = 3,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ISSUE_W = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NINS-1:0]                      ins_vld,
  input  logic [NINS-1:0][TAG_W-1:0]           ins_tag,
  input  logic [NINS-1:0][OP_W-1:0]            ins_op,
  input  logic [NINS-1:0][NSRC-1:0][TAG_W-1:0] ins_src_tag,
  input  logic [NINS-1:0][NSRC-1:0]            ins_src_rdy,
  output logic                                 ins_ready,
  input  logic [NCMP-1:0]                      cmp_vld,
  input  logic [NCMP-1:0][TAG_W-1:0]           cmp_tag,
  output logic [ISSUE_W-1:0]                   iss_vld,
  output logic [ISSUE_W-1:0][TAG_W-1:0]        iss_tag,
  output logic [ISSUE_W-1:0][OP_W-1:0]         iss_op
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned NENT  = DEPTH * NSRC;
  localparam int unsigned NLANE = NINS * NSRC;

  // Slot state
  logic [DEPTH-1:0]                      e_vld;
  logic [DEPTH-1:0][TAG_W-1:0]           e_tag;
  logic [DEPTH-1:0][OP_W-1:0]            e_op;
  logic [DEPTH-1:0][NSRC-1:0][TAG_W-1:0] e_stag;
  logic [DEPTH-1:0][NSRC-1:0]            e_srdy;

  logic [DEPTH-1:0]                      n_vld;
  logic [DEPTH-1:0][TAG_W-1:0]           n_tag;
  logic [DEPTH-1:0][OP_W-1:0]            n_op;
  logic [DEPTH-1:0][NSRC-1:0][TAG_W-1:0] n_stag;
  logic [DEPTH-1:0][NSRC-1:0]            n_srdy;

  // Admission: all offered lanes or none, judged on start-of-cycle occupancy
  logic [CW-1:0]   occ;
  logic [CW-1:0]   need;
  logic [NINS-1:0] ins_take;

  assign occ       = CW'($countones(e_vld));
  assign need      = CW'($countones(ins_vld));
  assign ins_ready = (need <= (CW'(DEPTH) - occ));
  assign ins_take  = ins_vld & {NINS{ins_ready}};

  // Wakeup of stored sources
  logic [NENT-1:0][TAG_W-1:0] ent_stag_f;
  logic [NENT-1:0]            ent_srdy_f;
  logic [NENT-1:0]            ent_ok_f;
  logic [DEPTH-1:0][NSRC-1:0] ent_ok;

  assign ent_stag_f = e_stag;
  assign ent_srdy_f = e_srdy;
  assign ent_ok     = ent_ok_f;

  iw_wake #(.TAG_W(TAG_W), .N(NENT)) u_wake_ent (
    .src_tag (ent_stag_f),
    .src_rdy (ent_srdy_f),
    .cmp_vld (cmp_vld),
    .cmp_tag (cmp_tag),
    .src_ok  (ent_ok_f)
  );

  // Wakeup of arriving sources
  logic [NLANE-1:0][TAG_W-1:0] lane_stag_f;
  logic [NLANE-1:0]            lane_srdy_f;
  logic [NLANE-1:0]            lane_ok_f;
  logic [NINS-1:0][NSRC-1:0]   lane_ok;

  assign lane_stag_f = ins_src_tag;
  assign lane_srdy_f = ins_src_rdy;
  assign lane_ok     = lane_ok_f;

  iw_wake #(.TAG_W(TAG_W), .N(NLANE)) u_wake_ins (
    .src_tag (lane_stag_f),
    .src_rdy (lane_srdy_f),
    .cmp_vld (cmp_vld),
    .cmp_tag (cmp_tag),
    .src_ok  (lane_ok_f)
  );

  // Issue request and selection
  logic [DEPTH-1:0]              req;
  logic [DEPTH-1:0]              gnt;
  logic [ISSUE_W-1:0]            pick_vld;
  logic [ISSUE_W-1:0][IDX_W-1:0] pick_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_req
    assign req[i] = e_vld[i] & (&ent_ok[i]);
  end

  iw_pick #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_pick (
    .req      (req),
    .gnt      (gnt),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      iss_vld[k] = pick_vld[k];
      iss_tag[k] = e_tag[pick_idx[k]];
      iss_op[k]  = e_op[pick_idx[k]];
    end
  end

  // Compaction and append
  iw_pack #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) u_pack (
    .cur_vld  (e_vld),
    .cur_tag  (e_tag),
    .cur_op   (e_op),
    .cur_stag (e_stag),
    .cur_srdy (ent_ok),
    .gnt      (gnt),
    .ins_take (ins_take),
    .ins_tag  (ins_tag),
    .ins_op   (ins_op),
    .ins_stag (ins_src_tag),
    .ins_srdy (lane_ok),
    .nxt_vld  (n_vld),
    .nxt_tag  (n_tag),
    .nxt_op   (n_op),
    .nxt_stag (n_stag),
    .nxt_srdy (n_srdy)
  );

  // State register with explicit enable
  logic upd_en;
  assign upd_en = (|gnt) | (|ins_take) | (|cmp_vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_tag  <= '0;
      e_op   <= '0;
      e_stag <= '0;
      e_srdy <= '0;
    end else if (upd_en) begin
      e_vld  <= n_vld;
      e_tag  <= n_tag;
      e_op   <= n_op;
      e_stag <= n_stag;
      e_srdy <= n_srdy;
    end
  end

  // Checks on the slot state and the issue ports
  a_r9_slots_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_vld & (e_vld + 1'b1)) == '0));

  a_r8_ports_packed: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_vld & (iss_vld + 1'b1)) == '0));

  a_r8_ready_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> iss_vld[0]);

  a_r8_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gnt) <= ISSUE_W));

  a_r10_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(e_vld) == $past($countones(e_vld))
              - $past($countones(iss_vld)) + $past($countones(ins_take))));

  a_r10_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ((&e_vld) && (|ins_vld)) |-> !ins_ready);
endmodule

// File: tb/iw_issue_window_test.sv
`timescale 1ns/1ps
module iw_issue_window_test;
  localparam int TAG_W   = 6;
  localparam int OP_W    = 3;
  localparam int DEPTH   = 8;
  localparam int ISSUE_W = 2;
  localparam int NP      = 63;  // reserved no-producer tag

  logic                          clk;
  logic                          rst_n;
  logic [1:0]                    ins_vld;
  logic [1:0][TAG_W-1:0]         ins_tag;
  logic [1:0][OP_W-1:0]          ins_op;
  logic [1:0][1:0][TAG_W-1:0]    ins_src_tag;
  logic [1:0][1:0]               ins_src_rdy;
  logic                          ins_ready;
  logic [1:0]                    cmp_vld;
  logic [1:0][TAG_W-1:0]         cmp_tag;
  logic [ISSUE_W-1:0]            iss_vld;
  logic [ISSUE_W-1:0][TAG_W-1:0] iss_tag;
  logic [ISSUE_W-1:0][OP_W-1:0]  iss_op;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  iw_issue_window #(.TAG_W(TAG_W), .OP_W(OP_W), .DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .ins_vld(ins_vld), .ins_tag(ins_tag), .ins_op(ins_op),
    .ins_src_tag(ins_src_tag), .ins_src_rdy(ins_src_rdy), .ins_ready(ins_ready),
    .cmp_vld(cmp_vld), .cmp_tag(cmp_tag),
    .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_op(iss_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic clr();
    ins_vld     = '0;
    ins_tag     = '0;
    ins_op      = '0;
    ins_src_tag = '0;
    ins_src_rdy = '0;
    cmp_vld     = '0;
    cmp_tag     = '0;
  endtask

  task automatic put(input int ln, input int tg, input int op,
                     input int ta, input bit ra, input int tb, input bit rb);
    ins_vld[ln]        = 1'b1;
    ins_tag[ln]        = TAG_W'(tg);
    ins_op[ln]         = OP_W'(op);
    ins_src_tag[ln][0] = TAG_W'(ta);
    ins_src_rdy[ln][0] = ra;
    ins_src_tag[ln][1] = TAG_W'(tb);
    ins_src_rdy[ln][1] = rb;
  endtask

  task automatic bc(input int p, input int tg);
    cmp_vld[p] = 1'b1;
    cmp_tag[p] = TAG_W'(tg);
  endtask

  // Inputs are set right after a falling edge; outputs settle, then sampled.
  task automatic settle();
    #2;
  endtask

  task automatic adv();
    @(negedge clk);
    clr();
  endtask

  task automatic see(input string r, input int v, input int t0, input int t1);
    chk({r, " iss_vld"}, int'(iss_vld), v);
    if (v[0]) chk({r, " iss_tag0"}, int'(iss_tag[0]), t0);
    if (v[1]) chk({r, " iss_tag1"}, int'(iss_tag[1]), t1);
  endtask

  task automatic t_reset();
    clr(); settle();
    see("R1 empty", 0, 0, 0);
    ins_vld = 2'b11; #1;
    chk("R1 ready when empty", int'(ins_ready), 1);
    ins_vld = 2'b00; #1;
    adv();
  endtask

  task automatic t_basic();
    put(0, 1, 2, NP, 0, NP, 0);   // R3: no producer on both sources
    put(1, 2, 5, 5, 1, NP, 0);    // R4: ready flag set on insert
    settle(); see("R2 not same cycle", 0, 0, 0);
    adv(); settle();
    see("R2 R3 R4 pair issues", 3, 1, 2);
    chk("R2 op port0", int'(iss_op[0]), 2);
    chk("R2 op port1", int'(iss_op[1]), 5);
    adv(); settle(); see("R11 gone", 0, 0, 0);
    adv();
  endtask

  task automatic t_wake();
    put(0, 3, 1, 7, 0, NP, 0);
    adv(); settle(); see("R5 waits", 0, 0, 0);
    adv(); bc(0, 7); settle(); see("R5 same cycle", 1, 3, 0);
    adv(); settle(); see("R11 after wake", 0, 0, 0);
    adv();
  endtask

  task automatic t_dual();
    put(0, 4, 0, 8, 0, 9, 0);
    put(1, 5, 0, 10, 0, 11, 0);
    adv(); bc(0, 8); settle(); see("R6 half woken", 0, 0, 0);
    adv(); bc(1, 9); settle(); see("R6 split wake", 1, 4, 0);
    adv(); bc(0, 11); bc(1, 10); settle(); see("R6 both ports", 1, 5, 0);
    adv(); settle(); see("R6 drained", 0, 0, 0);
    adv();
  endtask

  task automatic t_same();
    put(0, 6, 0, 12, 0, 13, 0);
    bc(0, 12); bc(1, 13);
    settle(); see("R7 arrival cycle", 0, 0, 0);
    adv(); settle(); see("R7 issues next", 1, 6, 0);
    adv(); settle(); see("R7 drained", 0, 0, 0);
    adv();
  endtask

  task automatic t_order();
    put(0, 20, 0, 30, 0, NP, 0);
    put(1, 21, 0, 31, 0, NP, 0);
    adv();
    put(0, 22, 0, 30, 0, NP, 0);
    put(1, 23, 0, 31, 0, NP, 0);
    adv();
    put(0, 24, 0, 30, 0, NP, 0);
    adv(); bc(0, 31); settle(); see("R8 oldest ready", 3, 21, 23);
    adv(); settle(); see("R11 no reissue", 0, 0, 0);
    adv(); bc(1, 30); settle(); see("R9 compacted order", 3, 20, 22);
    adv(); settle(); see("R9 stored wake kept", 1, 24, 0);
    adv(); settle(); see("R9 drained", 0, 0, 0);
    adv();
  endtask

  task automatic t_stall();
    put(0, 41, 1, 39, 0, NP, 0); put(1, 42, 1, 39, 0, NP, 0); adv();
    put(0, 43, 1, 39, 0, NP, 0); put(1, 44, 1, 39, 0, NP, 0); adv();
    put(0, 45, 1, 39, 0, NP, 0); put(1, 46, 1, 39, 0, NP, 0); adv();
    put(0, 47, 1, 39, 0, NP, 0); adv();
    put(0, 48, 1, 39, 0, NP, 0); put(1, 49, 1, NP, 0, NP, 0);
    settle(); chk("R10 two into one free", int'(ins_ready), 0);
    ins_vld[1] = 1'b0; #1;
    chk("R10 one into one free", int'(ins_ready), 1);
    adv();
    put(0, 50, 1, NP, 0, NP, 0);
    settle(); chk("R10 full", int'(ins_ready), 0);
    see("R10 full no issue", 0, 0, 0);
    adv(); settle(); see("R10 rejected ignored", 0, 0, 0);
    adv(); bc(0, 39); settle(); see("R10 drain a", 3, 41, 42);
    adv(); settle(); see("R10 drain b", 3, 43, 44);
    adv(); settle(); see("R10 drain c", 3, 45, 46);
    adv(); settle(); see("R10 drain d", 3, 47, 48);
    adv(); settle(); see("R10 drain end", 0, 0, 0);
    adv();
  endtask

  initial begin
    clr();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_wake();
    t_dual();
    t_same();
    t_order();
    t_stall();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule